// File: doc/BRIEF.md
# Chained Serial DAC Write Controller

This block is the host-side master for a string of serial 12-bit DACs connected output-to-input, sharing one clock line and one active-low select. A client hands it one 12-bit code per device over a valid/ready stream. Once it holds a code for every device, it pads each code into a 16-bit frame and shifts all frames out in a single select-low window. The clock runs in mode 0. Releasing the select then makes every device take its new code at the same moment.

Codes are taken in shift order. The first code accepted after a transfer is shifted first, so it travels furthest and lands in the device at the far end of the chain. The last code accepted lands in the device wired to `mosi`. Back-pressure is plain: `in_ready` is high only while the controller is idle and still short of a full set. A code moves only in a cycle where both `in_valid` and `in_ready` are high. While a transfer or its select-high recovery time is running, `in_ready` stays low and any code offered is held off.

An optional read-back path samples the chain's serial output on every rising clock edge. It compares those bits with the stream sent in the previous transfer, because a full chain returns exactly that stream one transfer later. The result is shown on `mismatch`.

Top module: `dac_chain_writer`

## Requirements
- R1: After reset, `cs_n`=1, `sclk`=0, `mosi`=0, `busy`=0, `in_ready`=1 and `mismatch`=0.
- R2: Exactly N_DEV codes are accepted per transfer, each in a cycle with `in_valid` and `in_ready` both high. `in_ready` is 0 whenever `busy` is 1.
- R3: Each code is sent as a 16-bit frame, MSB first: four zero fill bits, then the 12 code bits. The first code accepted is shifted first and ends in the farthest device. The last code accepted ends in the device fed directly by `mosi`.
- R4: `sclk` is low whenever `cs_n` is high. Its high and low phases inside a transfer each last HALF_CYC system clocks. `mosi` changes only while `sclk` is low, so it is stable across each rising edge.
- R5: One select-low window contains exactly N_DEV*16 rising edges of `sclk`. `cs_n` rises only after `sclk` has been low for HALF_CYC cycles.
- R6: On the rising edge of `cs_n`, each device's last 16 received bits hold its fill bits and its own code, in the placement given by R3.
- R7: `cs_n` stays high for at least CSHIGH_CYC system clocks between transfers. `busy` stays high from the start of a transfer until that interval has passed.
- R8: With read-back enabled, the chain output bit sampled at each rising `sclk` edge is compared with the bit sent at the same position in the previous transfer. `mismatch` is updated only when `cs_n` rises. It is never set by the first transfer after reset.
- R9: `mismatch` returns to 0 after a later transfer whose read-back matches.
- R10: A code offered while `busy` is high has no effect: it appears in no device after the following transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Code offered on `in_code` |
| in_ready | output | 1 | Controller can take a code this cycle |
| in_code | input | CODE_W | Code for the next device in shift order |
| sclk | output | 1 | Serial clock to the chain, idle low |
| cs_n | output | 1 | Shared active-low select; its rising edge updates every device |
| mosi | output | 1 | Serial data into the nearest device |
| miso | input | 1 | Serial data out of the farthest device |
| busy | output | 1 | Transfer or select-high recovery in progress |
| mismatch | output | 1 | Read-back of the last checked transfer differed |

## Verification
The bench builds the block with three devices, a two-cycle half period and a five-cycle select-high time, which gives a 48-edge window. With three devices, the ordering between near, middle and far device can be observed. With the half period shorter than the recovery time, a mix-up between the two counters is visible. A behavioural chain of three 16-bit shift registers, each with a falling-edge output stage, returns the previous stream, so the read-back path is reached. Forcing the returned data wrong shows whether the flag behaves on the first transfer after reset, on a bad transfer, and on the recovery that follows.

// File: rtl/dcw_pkg.sv
package dcw_pkg;
  typedef enum logic [2:0] {
    SER_IDLE,
    SER_LOW,
    SER_HIGH,
    SER_END,
    SER_GAP
  } ser_state_t;

  localparam int FILL_BITS = 4;
endpackage

// File: rtl/dcw_frame_buf.sv
module dcw_frame_buf #(
  parameter int N_DEV   = 3,
  parameter int CODE_W  = 12,
  parameter int FRAME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CODE_W-1:0] code,
  input  logic              take,
  input  logic              shift,
  output logic              top_bit,
  output logic              full
);
  localparam int TOT = N_DEV * FRAME_W;
  localparam int CW  = $clog2(N_DEV + 1);

  logic [TOT-1:0] stream;
  logic [CW-1:0]  cnt;

  assign full    = (cnt == CW'(N_DEV));
  assign top_bit = stream[TOT-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stream <= '0;
      cnt    <= '0;
    end else begin
      if (load) begin
        // new frame enters at the low end; upper fill bits come in as zeros
        stream <= (stream << FRAME_W) | {{(TOT-CODE_W){1'b0}}, code};
        cnt    <= cnt + CW'(1);
      end else if (shift) begin
        stream <= {stream[TOT-2:0], 1'b0};
      end
      if (take) cnt <= '0;
    end
  end

  // R2
  load_not_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (cnt < CW'(N_DEV)));
  // R2
  take_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full);
  // R10
  no_load_while_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift |-> !load);
endmodule

// File: rtl/dcw_serializer.sv
module dcw_serializer
  import dcw_pkg::*;
#(
  parameter int TOT        = 48,
  parameter int HALF_CYC   = 2,
  parameter int CSHIGH_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frames_ready,
  output logic sclk,
  output logic cs_n,
  output logic take,
  output logic shift,
  output logic rise_evt,
  output logic xfer_end,
  output logic busy
);
  localparam int TMAX = (HALF_CYC > CSHIGH_CYC) ? HALF_CYC : CSHIGH_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int BW   = $clog2(TOT + 1);

  ser_state_t    state;
  logic [TW-1:0] tcnt;
  logic [BW-1:0] bits_left;
  logic          half_done, gap_done;

  assign half_done = (tcnt == TW'(HALF_CYC - 1));
  assign gap_done  = (tcnt == TW'(CSHIGH_CYC - 1));
  assign take      = (state == SER_IDLE) && frames_ready;
  assign rise_evt  = (state == SER_LOW)  && half_done;
  assign shift     = (state == SER_HIGH) && half_done;
  assign xfer_end  = (state == SER_END)  && half_done;
  assign busy      = (state != SER_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SER_IDLE;
      tcnt      <= '0;
      bits_left <= '0;
      sclk      <= 1'b0;
      cs_n      <= 1'b1;
    end else begin
      unique case (state)
        SER_IDLE: begin
          tcnt <= '0;
          if (frames_ready) begin
            cs_n      <= 1'b0;
            bits_left <= BW'(TOT);
            state     <= SER_LOW;
          end
        end
        SER_LOW: begin
          if (half_done) begin
            sclk  <= 1'b1;
            tcnt  <= '0;
            state <= SER_HIGH;
          end else tcnt <= tcnt + TW'(1);
        end
        SER_HIGH: begin
          if (half_done) begin
            sclk      <= 1'b0;
            tcnt      <= '0;
            bits_left <= bits_left - BW'(1);
            state     <= (bits_left == BW'(1)) ? SER_END : SER_LOW;
          end else tcnt <= tcnt + TW'(1);
        end
        SER_END: begin
          if (half_done) begin
            cs_n  <= 1'b1;
            tcnt  <= '0;
            state <= SER_GAP;
          end else tcnt <= tcnt + TW'(1);
        end
        SER_GAP: begin
          if (gap_done) begin
            tcnt  <= '0;
            state <= SER_IDLE;
          end else tcnt <= tcnt + TW'(1);
        end
        default: state <= SER_IDLE;
      endcase
    end
  end

  // R5
  all_bits_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (bits_left == '0));
  // R4
  clock_low_at_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> !sclk);
  // R7
  busy_through_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> busy);
endmodule

// File: rtl/dcw_readback.sv
module dcw_readback #(
  parameter int TOT = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_evt,
  input  logic sent_bit,
  input  logic miso,
  input  logic xfer_start,
  input  logic xfer_end,
  output logic mismatch
);
  logic [TOT-1:0] sent_sr, prev_sr;
  logic           prev_ok, err_acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sent_sr  <= '0;
      prev_sr  <= '0;
      prev_ok  <= 1'b0;
      err_acc  <= 1'b0;
      mismatch <= 1'b0;
    end else begin
      if (xfer_start) err_acc <= 1'b0;
      if (rise_evt) begin
        sent_sr <= {sent_sr[TOT-2:0], sent_bit};
        prev_sr <= {prev_sr[TOT-2:0], 1'b0};
        if (prev_ok && (miso != prev_sr[TOT-1])) err_acc <= 1'b1;
      end
      if (xfer_end) begin
        prev_sr  <= sent_sr;
        prev_ok  <= 1'b1;
        mismatch <= prev_ok && err_acc;
      end
    end
  end

  // R8
  flag_moves_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_end |=> $stable(mismatch));
  // R8
  first_xfer_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_end && !prev_ok) |=> !mismatch);
endmodule

// File: rtl/dac_chain_writer.sv
module dac_chain_writer #(
  parameter int N_DEV      = 3,
  parameter int CODE_W     = 12,
  parameter int FRAME_W    = 16,
  parameter int HALF_CYC   = 2,
  parameter int CSHIGH_CYC = 5,
  parameter bit CHECK_EN   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CODE_W-1:0] in_code,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso,
  output logic              busy,
  output logic              mismatch
);
  localparam int TOT = N_DEV * FRAME_W;
  localparam int HW  = $clog2(CSHIGH_CYC + 1);

  logic full, top_bit, load, take, shift, rise_evt, xfer_end;

  assign in_ready = !full && !busy;
  assign load     = in_valid && in_ready;
  assign mosi     = !cs_n && top_bit;

  dcw_frame_buf #(.N_DEV(N_DEV), .CODE_W(CODE_W), .FRAME_W(FRAME_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .load(load), .code(in_code), .take(take),
    .shift(shift), .top_bit(top_bit), .full(full)
  );

  dcw_serializer #(.TOT(TOT), .HALF_CYC(HALF_CYC), .CSHIGH_CYC(CSHIGH_CYC)) u_ser (
    .clk(clk), .rst_n(rst_n), .frames_ready(full), .sclk(sclk), .cs_n(cs_n),
    .take(take), .shift(shift), .rise_evt(rise_evt), .xfer_end(xfer_end), .busy(busy)
  );

  generate
    if (CHECK_EN) begin : g_rb
      dcw_readback #(.TOT(TOT)) u_rb (
        .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .sent_bit(top_bit),
        .miso(miso), .xfer_start(take), .xfer_end(xfer_end), .mismatch(mismatch)
      );
    end else begin : g_no_rb
      assign mismatch = 1'b0;
    end
  endgenerate

  // select-high length seen at the ports, saturating
  logic [HW-1:0] hi_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) hi_cnt <= HW'(CSHIGH_CYC);
    else if (!cs_n) hi_cnt <= '0;
    else if (hi_cnt != HW'(CSHIGH_CYC)) hi_cnt <= hi_cnt + HW'(1);
  end

  // R4
  clock_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  // R4
  data_stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));
  // R5
  select_rise_low_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (!sclk && !$past(sclk)));
  // R7
  min_high_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> ($past(hi_cnt) == HW'(CSHIGH_CYC)));
  // R2
  ready_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);
endmodule

// File: tb/sim_dac_chain_writer.sv
module sim_dac_chain_writer;
  localparam int N     = 3;
  localparam int CW    = 12;
  localparam int HALF  = 2;
  localparam int CSHI  = 5;
  localparam int TOT   = N * 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [CW-1:0] in_code = '0;
  logic in_ready, sclk, cs_n, mosi, miso, busy, mismatch;
  logic corrupt = 1'b0;
  int   errors = 0, checks = 0;

  always #2 clk = ~clk;

  dac_chain_writer #(.N_DEV(N), .CODE_W(CW), .FRAME_W(16), .HALF_CYC(HALF),
                     .CSHIGH_CYC(CSHI), .CHECK_EN(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .busy(busy), .mismatch(mismatch)
  );

  // behavioural device chain: device 0 is fed by mosi
  logic [15:0]   sr [N];
  logic          dout [N];
  logic          din_w [N];
  logic [CW-1:0] latched [N];
  initial for (int k = 0; k < N; k++) begin sr[k] = '0; dout[k] = 1'b0; latched[k] = '0; end
  always_comb begin
    din_w[0] = mosi;
    for (int k = 1; k < N; k++) din_w[k] = dout[k-1];
  end
  always @(posedge sclk) if (!cs_n) for (int k = 0; k < N; k++) sr[k] <= {sr[k][14:0], din_w[k]};
  always @(negedge sclk) if (!cs_n) for (int k = 0; k < N; k++) dout[k] <= sr[k][15];
  always @(posedge cs_n) for (int k = 0; k < N; k++) latched[k] <= sr[k][CW-1:0];
  assign miso = dout[N-1] ^ corrupt;

  // port monitors
  int rises = 0, last_rises = 0, phase_viol = 0, mosi_viol = 0;
  int hi_len = 0, lo_len = 0, gap = 0, min_gap = 1000, ready_gap_viol = 0;
  logic p_sclk = 1'b0, p_mosi = 1'b0, seen_xfer = 1'b0;
  always @(posedge sclk) if (!cs_n) rises <= rises + 1;
  always @(posedge cs_n) begin last_rises <= rises; rises <= 0; end
  always @(posedge clk) if (rst_n) begin
    p_sclk <= sclk; p_mosi <= mosi;
    if (sclk && p_sclk && (mosi != p_mosi)) mosi_viol <= mosi_viol + 1;
    if (sclk) hi_len <= hi_len + 1;
    else begin
      if (p_sclk && hi_len != HALF) phase_viol <= phase_viol + 1;
      hi_len <= 0;
    end
    if (!cs_n && !sclk) lo_len <= lo_len + 1;
    else begin
      if (sclk && !p_sclk && lo_len != HALF) phase_viol <= phase_viol + 1;
      lo_len <= 0;
    end
    if (cs_n) begin
      gap <= gap + 1;
      if (seen_xfer && gap < CSHI && in_ready) ready_gap_viol <= ready_gap_viol + 1;
    end else begin
      if (seen_xfer && gap > 0 && gap < min_gap) min_gap <= gap;
      gap <= 0;
      seen_xfer <= 1'b1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_set(input logic [CW-1:0] c0, input logic [CW-1:0] c1, input logic [CW-1:0] c2);
    logic [CW-1:0] cs [N];
    cs[0] = c0; cs[1] = c1; cs[2] = c2;
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_code = cs[i];
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    while (!busy) @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic expect_devs(input string req, input logic [CW-1:0] c0, input logic [CW-1:0] c1, input logic [CW-1:0] c2);
    chk(req, latched[N-1], c0); // first accepted -> farthest
    chk(req, latched[1], c1);
    chk(req, latched[0], c2);   // last accepted -> nearest
  endtask

  task automatic t_reset();
    chk("R1 cs_n", cs_n, 1); chk("R1 sclk", sclk, 0); chk("R1 mosi", mosi, 0);
    chk("R1 busy", busy, 0); chk("R1 in_ready", in_ready, 1); chk("R1 mismatch", mismatch, 0);
  endtask

  task automatic t_first_no_flag();
    corrupt = 1'b1;
    push_set(12'h111, 12'h222, 12'h333);
    corrupt = 1'b0;
    chk("R8 first transfer not flagged", mismatch, 0);
  endtask

  task automatic t_basic();
    push_set(12'hABC, 12'h5A5, 12'h0F1);
    expect_devs("R3 R6 order", 12'hABC, 12'h5A5, 12'h0F1);
    for (int k = 0; k < N; k++) chk("R3 fill bits zero", sr[k][15:12], 0);
    chk("R5 rising edges per window", last_rises, TOT);
    chk("R4 phase lengths", phase_viol, 0);
    chk("R4 mosi stable while high", mosi_viol, 0);
    chk("R8 clean readback", mismatch, 0);
  endtask

  task automatic t_patterns();
    push_set(12'hFFF, 12'h000, 12'h800);
    expect_devs("R6 extremes", 12'hFFF, 12'h000, 12'h800);
    push_set(12'h001, 12'hFFE, 12'h7FF);
    expect_devs("R6 edges", 12'h001, 12'hFFE, 12'h7FF);
    chk("R5 rising edges", last_rises, TOT);
  endtask

  task automatic t_backpressure();
    int rdy_busy = 0;
    fork
      push_set(12'h321, 12'h654, 12'h987);
      begin
        while (!busy) @(negedge clk);
        repeat (20) begin
          @(negedge clk);
          in_valid = 1'b1; in_code = 12'hBAD;
          if (in_ready) rdy_busy++;
        end
        in_valid = 1'b0;
      end
    join
    chk("R2 ready low while busy", rdy_busy, 0);
    expect_devs("R10 offered code ignored", 12'h321, 12'h654, 12'h987);
    push_set(12'h444, 12'h555, 12'h666);
    expect_devs("R10 next set intact", 12'h444, 12'h555, 12'h666);
  endtask

  task automatic t_gap();
    push_set(12'h010, 12'h020, 12'h030);
    push_set(12'h040, 12'h050, 12'h060);
    chk("R7 min select-high", (min_gap >= CSHI), 1);
    chk("R7 ready held during recovery", ready_gap_viol, 0);
  endtask

  task automatic t_mismatch();
    corrupt = 1'b1;
    push_set(12'h0AA, 12'h0BB, 12'h0CC);
    corrupt = 1'b0;
    chk("R8 bad readback flagged", mismatch, 1);
    push_set(12'h0DD, 12'h0EE, 12'h0FF);
    chk("R9 flag clears", mismatch, 0);
  endtask

  logic done = 1'b0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_no_flag();
    t_basic();
    t_patterns();
    t_backpressure();
    t_gap();
    t_mismatch();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule